// File: doc/BRIEF.md
# PHY register access controller

This block sits on the link side of a serial-bus node. Host software reaches the registers of the physical-layer device through it, using one 32-bit control word. Software picks a 4-bit register address. For writes it also gives an 8-bit value. It then sets either the read command bit or the write command bit. The controller turns the command into a serial request frame on a single link-request line. The command bit clears itself once the last bit of that frame has left.

The PHY answers reads asynchronously with a register echo. The echo is modelled here as a one-cycle strobe that carries an address and a data byte. The controller stores both in the control word and raises a done flag. It also sets a sticky interrupt flag, which software clears by writing a one to it through a second select. Register writes count as finished once their frame has gone out, and they never touch the done flag. Only one operation may be in flight. A second command while busy is refused, and so is a word that asks for both operations at once. Either case raises a sticky protocol-error flag.

Top module: `phy_regctl`

## Requirements
- R1: After a synchronous active-low reset, both command bits (15 read, 14 write), the reserved bits (30:28 and 13:12), the link-request line, the interrupt flag and the protocol-error flag are all 0.
- R2: A control write (host_sel=0) with bit 15 set, while idle, sends on lreq, starting in the cycle after the write and one bit per cycle with the MSB first: a start 1, the type 3'b101, the 4-bit address taken from bits 11:8, then a stop 0. That is 9 bits in total.
- R3: A control write with bit 14 set, while idle, sends a start 1, the type 3'b110, the address from bits 11:8, the data byte from bits 7:0 and a stop 0. That is 17 bits in total.
- R4: The accepted command bit reads 1 for the whole time its frame is being sent and reads 0 from the cycle after the stop bit. lreq is 0 whenever no command is pending.
- R5: Accepting a command clears the done flag (bit 31).
- R6: A response strobe (rsp_valid) stores rsp_addr in bits 27:24 and rsp_data in bits 23:16, and sets bit 31, all visible in the next cycle.
- R7: A response sets the interrupt flag. The flag stays set until a status write (host_sel=1) with bit 0 set. If a set and a clear fall in the same cycle, the set wins.
- R8: A control write that asks for a command while one is pending, or that sets bits 15 and 14 together, is rejected. It starts no frame and changes no field, and it sets proto_err. A status write with bit 1 set clears proto_err, and a rejection in the same cycle wins over that clear.
- R9: A register write finishes without any response, and its completion leaves the done flag at 0.
- R10: While idle, a control write stores bits 11:8 and 7:0 so they read back unchanged. Reserved bits always read 0, and bits 31:16 of the written word are ignored.
- R11: A response in the same cycle as an accepted command leaves the done flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0: control word, 1: status clear word |
| host_wdata | input | 32 | Host write data |
| ctrl_q | output | 32 | Control word read value |
| irq | output | 1 | Register-received interrupt flag |
| proto_err | output | 1 | Protocol-error flag |
| lreq | output | 1 | Serial link-request line to the PHY |
| rsp_valid | input | 1 | PHY register echo strobe |
| rsp_addr | input | 4 | Echoed register address |
| rsp_data | input | 8 | Echoed register data |

## Verification
The assertions assume only that the inputs are known once reset has been released. They assume nothing about host behaviour, so illegal commands, double commands and responses colliding with commands all fall inside what they check. The stimulus uses this freedom on purpose. Directed cases hit the busy rejection, the both-bits rejection, the set-versus-clear collisions and the response-versus-command collision. A long random phase then mixes control writes, status writes and response strobes with no protocol discipline, and every cycle is compared against a behavioural model that holds the outgoing frame as a bit queue.

// File: rtl/phy_regctl_pkg.sv
// Package: shared constants and types for the PHY register access controller.
// Assumes a fixed 32-bit control word whose field positions are software-visible.
package phy_regctl_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int TYPE_W    = 3;
    localparam logic [TYPE_W-1:0] TYPE_RD = 3'b101;
    localparam logic [TYPE_W-1:0] TYPE_WR = 3'b110;
    localparam int FRAME_RD_LEN = 1 + TYPE_W + ADDR_W + 1;
    localparam int FRAME_WR_LEN = FRAME_RD_LEN + DATA_W;

    localparam int POS_DONE  = 31;
    localparam int POS_RADDR = 24;
    localparam int POS_RDATA = 16;
    localparam int POS_RDCMD = 15;
    localparam int POS_WRCMD = 14;
    localparam int POS_TADDR = 8;
    localparam int POS_WDATA = 0;
    localparam int STAT_IRQ  = 0;
    localparam int STAT_PERR = 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_xfer_t;
endpackage

// File: rtl/phy_regctl_gate.sv
// Module: command gate. Decodes a host control write against the busy state.
// Assumes host_sel=0 selects the control word. Purely combinational.
module phy_regctl_gate (
    input  logic host_we,
    input  logic host_sel,
    input  logic want_rd,
    input  logic want_wr,
    input  logic busy,
    output logic fields_we,
    output logic start_rd,
    output logic start_wr,
    output logic reject
);
    logic ctl_w;
    logic both;

    // Classify the write: field update, start of a command, or rejection.
    always_comb begin
        ctl_w     = host_we && !host_sel;
        both      = want_rd && want_wr;
        reject    = ctl_w && (both || (busy && (want_rd || want_wr)));
        fields_we = ctl_w && !busy && !both;
        start_rd  = fields_we && want_rd;
        start_wr  = fields_we && want_wr;
    end
endmodule

// File: rtl/phy_regctl_tx.sv
// Module: request frame serializer. Loads a read or write frame and shifts it
// out MSB first, one bit per cycle. Assumes load only arrives while idle.
module phy_regctl_tx
    import phy_regctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              lreq,
    output logic              last
);
    localparam int CNT_W = $clog2(FRAME_WR_LEN + 1);

    logic [FRAME_WR_LEN-1:0] shreg;
    logic [CNT_W-1:0]        cnt;

    // Load a frame left-justified, then shift one bit per cycle until empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (load) begin
            if (is_write) begin
                shreg <= {1'b1, TYPE_WR, addr, data, 1'b0};
                cnt   <= CNT_W'(FRAME_WR_LEN);
            end else begin
                shreg <= {1'b1, TYPE_RD, addr, 1'b0, {DATA_W{1'b0}}};
                cnt   <= CNT_W'(FRAME_RD_LEN);
            end
        end else if (cnt != '0) begin
            shreg <= {shreg[FRAME_WR_LEN-2:0], 1'b0};
            cnt   <= cnt - CNT_W'(1);
        end
    end

    // Present the head bit and flag the final (stop) bit.
    always_comb begin
        lreq = shreg[FRAME_WR_LEN-1];
        last = (cnt == CNT_W'(1));
    end

    AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n) load |=> lreq); // R2
    AST_NO_RELOAD:   assert property (@(posedge clk) disable iff (!rst_n) load |-> (cnt == '0)); // R8
    AST_STOP_LOW:    assert property (@(posedge clk) disable iff (!rst_n) last |-> !lreq); // R3
endmodule

// File: rtl/phy_regctl_rsp.sv
// Module: response capture. Stores the PHY's register echo and keeps the
// done and interrupt flags. Assumes rsp_addr and rsp_data are valid with rsp_valid.
module phy_regctl_rsp
    import phy_regctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rsp_valid,
    input  reg_xfer_t rsp_in,
    input  logic      cmd_start,
    input  logic      irq_clr,
    output reg_xfer_t ret,
    output logic      done,
    output logic      irq
);
    // Capture the echoed address and data on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         ret <= '0;
        else if (rsp_valid) ret <= rsp_in;
    end

    // Done: set by a response, cleared by a new command; the response wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         done <= 1'b0;
        else if (rsp_valid) done <= 1'b1;
        else if (cmd_start) done <= 1'b0;
    end

    // Interrupt: sticky until written one to clear; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (rsp_valid) irq <= 1'b1;
        else if (irq_clr)   irq <= 1'b0;
    end

    AST_RSP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (done && ret == $past(rsp_in))); // R6
    AST_CMD_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !rsp_valid) |=> !done); // R5
    AST_RSP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && rsp_valid) |=> done); // R11
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R7
endmodule

// File: rtl/phy_regctl.sv
// Module: PHY register access controller top. Holds the control word and the
// command and error state, and wires the gate, serializer and capture together.
// Assumes one host write per cycle and synchronous active-low reset.
module phy_regctl
    import phy_regctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] ctrl_q,
    output logic        irq,
    output logic        proto_err,
    output logic        lreq,
    input  logic        rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data
);
    logic              rd_cmd, wr_cmd, busy;
    logic [ADDR_W-1:0] taddr;
    logic [DATA_W-1:0] wdat;
    logic              fields_we, start_rd, start_wr, reject;
    logic              tx_last, done, irq_clr, perr_clr;
    reg_xfer_t         ret, rsp_in;
    logic              unused_bits;

    assign busy        = rd_cmd || wr_cmd;
    assign irq_clr     = host_we && host_sel && host_wdata[STAT_IRQ];
    assign perr_clr    = host_we && host_sel && host_wdata[STAT_PERR];
    assign rsp_in      = '{addr: rsp_addr, data: rsp_data};
    assign unused_bits = ^{host_wdata[31:16], host_wdata[13:12]};

    phy_regctl_gate gate_i (
        .host_we   (host_we),
        .host_sel  (host_sel),
        .want_rd   (host_wdata[POS_RDCMD]),
        .want_wr   (host_wdata[POS_WRCMD]),
        .busy      (busy),
        .fields_we (fields_we),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .reject    (reject)
    );

    phy_regctl_tx tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_rd || start_wr),
        .is_write (start_wr),
        .addr     (host_wdata[POS_TADDR +: ADDR_W]),
        .data     (host_wdata[POS_WDATA +: DATA_W]),
        .lreq     (lreq),
        .last     (tx_last)
    );

    phy_regctl_rsp rsp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_valid (rsp_valid),
        .rsp_in    (rsp_in),
        .cmd_start (start_rd || start_wr),
        .irq_clr   (irq_clr),
        .ret       (ret),
        .done      (done),
        .irq       (irq)
    );

    // Command bits: set on acceptance, cleared when the stop bit has gone out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cmd <= 1'b0;
            wr_cmd <= 1'b0;
        end else begin
            if (start_rd)     rd_cmd <= 1'b1;
            else if (tx_last) rd_cmd <= 1'b0;
            if (start_wr)     wr_cmd <= 1'b1;
            else if (tx_last) wr_cmd <= 1'b0;
        end
    end

    // Target address and write data: updated only by an accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taddr <= '0;
            wdat  <= '0;
        end else if (fields_we) begin
            taddr <= host_wdata[POS_TADDR +: ADDR_W];
            wdat  <= host_wdata[POS_WDATA +: DATA_W];
        end
    end

    // Protocol error: sticky; a rejection wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        proto_err <= 1'b0;
        else if (reject)   proto_err <= 1'b1;
        else if (perr_clr) proto_err <= 1'b0;
    end

    // Assemble the software-visible control word.
    always_comb begin
        ctrl_q = '0;
        ctrl_q[POS_DONE]                  = done;
        ctrl_q[POS_RADDR +: ADDR_W]       = ret.addr;
        ctrl_q[POS_RDATA +: DATA_W]       = ret.data;
        ctrl_q[POS_RDCMD]                 = rd_cmd;
        ctrl_q[POS_WRCMD]                 = wr_cmd;
        ctrl_q[POS_TADDR +: ADDR_W]       = taddr;
        ctrl_q[POS_WDATA +: DATA_W]       = wdat;
    end

    AST_CMD_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(rd_cmd && wr_cmd)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !lreq); // R4
    AST_CMD_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_last) |=> $stable({rd_cmd, wr_cmd})); // R4
    AST_PERR_SET:   assert property (@(posedge clk) disable iff (!rst_n) reject |=> proto_err); // R8
    AST_REJECT_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && !busy) |=> ($stable(taddr) && $stable(wdat) && !busy)); // R8
endmodule

// File: tb/phy_regctl_tb_top.sv
`timescale 1ns/1ps
module phy_regctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] ctrl_q;
    logic        irq, proto_err, lreq;
    logic        rsp_valid = 1'b0;
    logic [3:0]  rsp_addr = '0;
    logic [7:0]  rsp_data = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    phy_regctl dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .ctrl_q(ctrl_q), .irq(irq), .proto_err(proto_err),
        .lreq(lreq), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
    );

    // Behavioural reference model
    bit       m_rd, m_wr, m_done, m_dk, m_fk, m_irq, m_perr;
    bit [3:0] m_addr, m_raddr;
    bit [7:0] m_wd, m_rdata;
    bit       q[$];

    task automatic push_frame(bit wr, bit [3:0] a, bit [7:0] d);
        q.push_back(1'b1);
        if (wr) begin q.push_back(1); q.push_back(1); q.push_back(0); end
        else    begin q.push_back(1); q.push_back(0); q.push_back(1); end
        for (int i = 3; i >= 0; i--) q.push_back(a[i]);
        if (wr) for (int i = 7; i >= 0; i--) q.push_back(d[i]);
        q.push_back(1'b0);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rd = 0; m_wr = 0; m_done = 0; m_dk = 0; m_fk = 0;
            m_irq = 0; m_perr = 0; m_addr = 0; m_wd = 0; q.delete();
        end else begin
            bit busy;
            busy = m_rd | m_wr;
            if (q.size() > 0) begin
                void'(q.pop_front());
                if (q.size() == 0) begin m_rd = 0; m_wr = 0; end
            end
            if (host_we && !host_sel) begin
                bit wr_b, rd_b;
                rd_b = host_wdata[15]; wr_b = host_wdata[14];
                if ((rd_b && wr_b) || (busy && (rd_b || wr_b))) m_perr = 1;
                else if (!busy) begin
                    m_addr = host_wdata[11:8]; m_wd = host_wdata[7:0];
                    if (rd_b || wr_b) begin
                        m_rd = rd_b; m_wr = wr_b; m_done = 0; m_dk = 1;
                        push_frame(wr_b, m_addr, m_wd);
                    end
                end
            end
            if (host_we && host_sel) begin
                if (host_wdata[0]) m_irq = 0;
                if (host_wdata[1]) m_perr = 0;
            end
            if (rsp_valid) begin
                m_raddr = rsp_addr; m_rdata = rsp_data;
                m_done = 1; m_dk = 1; m_fk = 1; m_irq = 1;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 R3 lreq", {31'b0, lreq}, {31'b0, (q.size() > 0) ? q[0] : 1'b0});
            chk("R4 cmd bits", {30'b0, ctrl_q[15:14]}, {30'b0, m_rd, m_wr});
            chk("R10 fields", {20'b0, ctrl_q[11:0]}, {20'b0, m_addr, m_wd});
            chk("R10 reserved", ctrl_q & 32'h7000_3000, 32'h0);
            if (m_dk) chk("R5 R6 done", {31'b0, ctrl_q[31]}, {31'b0, m_done});
            if (m_fk) chk("R6 returned", {20'b0, ctrl_q[27:16]}, {20'b0, m_raddr, m_rdata});
            chk("R7 irq", {31'b0, irq}, {31'b0, m_irq});
            chk("R8 proto_err", {31'b0, proto_err}, {31'b0, m_perr});
        end
    end

    task automatic cyc(bit we, bit sel, logic [31:0] wd, bit rv, logic [3:0] ra, logic [7:0] rdt);
        @(negedge clk);
        host_we = we; host_sel = sel; host_wdata = wd;
        rsp_valid = rv; rsp_addr = ra; rsp_data = rdt;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 32'h0, 0, 4'h0, 8'h0);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 cmd+reserved", ctrl_q & 32'h7000_F000, 32'h0);
        chk("R1 outputs", {29'b0, lreq, irq, proto_err}, 32'h0);

        // R2 read of address 5
        cyc(1, 0, 32'h0000_8500, 0, 0, 0);
        idle(1);
        chk("R4 read pending", {31'b0, ctrl_q[15]}, 32'h1);
        chk("R2 start bit", {31'b0, lreq}, 32'h1);
        idle(9);
        chk("R4 read cleared", {31'b0, ctrl_q[15]}, 32'h0);

        // R6 R7 response
        cyc(0, 0, 32'h0, 1, 4'h5, 8'hA7);
        idle(1);
        chk("R6 capture", {16'b0, ctrl_q[31:16]}, 32'h0000_85A7);
        chk("R7 irq set", {31'b0, irq}, 32'h1);

        // R3 write, R5 done cleared, R8 busy rejection
        cyc(1, 0, 32'h0000_435C, 0, 0, 0);
        idle(1);
        chk("R5 done cleared", {31'b0, ctrl_q[31]}, 32'h0);
        cyc(1, 0, 32'h0000_8900, 0, 0, 0);
        idle(1);
        chk("R8 busy reject", {31'b0, proto_err}, 32'h1);
        chk("R8 fields kept", {20'b0, ctrl_q[11:0]}, 32'h35C);
        idle(20);
        chk("R9 write done", {30'b0, ctrl_q[31], ctrl_q[14]}, 32'h0);
        chk("R7 irq sticky", {31'b0, irq}, 32'h1);

        cyc(1, 1, 32'h3, 0, 0, 0);
        idle(1);
        chk("R7 R8 cleared", {30'b0, irq, proto_err}, 32'h0);

        // R8 both bits set
        cyc(1, 0, 32'h0000_C7AA, 0, 0, 0);
        idle(1);
        chk("R8 both rejected", {29'b0, proto_err, ctrl_q[15:14]}, 32'h4);
        chk("R8 no frame", {31'b0, lreq}, 32'h0);
        cyc(1, 1, 32'h2, 0, 0, 0);

        // R10 field write, upper half ignored
        cyc(1, 0, 32'hFFFF_3F12, 0, 0, 0);
        idle(1);
        chk("R10 readback", ctrl_q & 32'h7000_FFFF, 32'h0000_0F12);

        // R11 response collides with command
        cyc(1, 0, 32'h0000_8200, 1, 4'h9, 8'h3C);
        idle(1);
        chk("R11 done kept", {30'b0, ctrl_q[31], ctrl_q[15]}, 32'h3);
        idle(12);

        // R7 set wins over clear
        cyc(1, 1, 32'h1, 1, 4'h2, 8'h11);
        idle(1);
        chk("R7 set wins", {31'b0, irq}, 32'h1);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            bit we, rv;
            we = ($urandom % 4) == 0;
            rv = ($urandom % 8) == 0;
            cyc(we, ($urandom % 3) == 0, $urandom, rv, 4'($urandom), 8'($urandom));
        end
        idle(25);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end
endmodule